// File: doc/BRIEF.md
# Segment Access Rights Checker

This block judges a single memory reference against the descriptor of the segment it falls in. From the descriptor it takes the segment length, counted in pages, and a two-bit rights class. From the request it takes the page number within the segment, the kind of reference (instruction fetch, data load or data store) and whether the processor is in supervisor mode. It returns a grant, plus two separate fault flags: one for a page beyond the segment length and one for a reference the rights class forbids.

The page-table base in the descriptor is not used here, because translation happens elsewhere. Descriptor loading and the fault response are also handled outside this block. The check itself is pure logic. A parameter selects either a registered result stage, which adds one cycle, or a direct combinational path.

Top module: `seg_guard`

## Requirements
- R1: `size_viol` is raised exactly when `acc_page` is greater than or equal to `seg_len`, compared as unsigned numbers. A length of 0 therefore faults every page.
- R2: Rights class 2'b00 (read/write) permits all three reference kinds.
- R3: Rights class 2'b01 (read-only) permits fetches and loads but raises `access_viol` on every store.
- R4: Rights class 2'b10 (execute-only) permits fetches only and raises `access_viol` on loads and stores.
- R5: Rights class 2'b11 (system-only) raises `access_viol` on every reference made with `acc_super` low, and permits all three kinds with `acc_super` high.
- R6: For rights classes 2'b00, 2'b01 and 2'b10, `acc_super` has no effect on the outcome.
- R7: Reference kinds are encoded as fetch 2'b00, load 2'b01 and store 2'b10. The code 2'b11 is invalid and always raises `access_viol`, whatever the rights class or mode.
- R8: Both fault flags may be raised together. `grant` is high only when neither flag is raised.
- R9: With REGISTERED=1, each result appears one clock after its inputs. An active-low `rst_n` clears `grant`, `size_viol` and `access_viol` to 0 at once and holds them there.
- R10: With REGISTERED=0, the outputs follow the inputs in the same cycle and are unaffected by `rst_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the registered result stage |
| rst_n | input | 1 | Asynchronous active-low reset |
| seg_len | input | LEN_W | Segment length in pages, from the descriptor |
| seg_rights | input | 2 | Rights class from the descriptor |
| acc_page | input | PAGE_W | Page number within the segment |
| acc_kind | input | 2 | Reference kind: fetch, load, store or invalid |
| acc_super | input | 1 | High when the reference is made in supervisor mode |
| grant | output | 1 | Reference allowed |
| size_viol | output | 1 | Page beyond segment length |
| access_viol | output | 1 | Reference forbidden by the rights class |

## Verification
The bench builds two copies of the block, both with PAGE_W=8 and LEN_W=9. One copy has REGISTERED=1 and the other REGISTERED=0, and both are fed the same stimulus, so the one-cycle delay and the direct path can be compared on every vector. Because the length field is one bit wider than the page field, both edge cases are reachable: a length of 256 admits page 255, and a length of 0 rejects page 0. The boundary case where the page equals the length can also be driven directly. The reset tests apply `rst_n` while the inputs would grant a reference, which separates the reset value from a real result.

// File: rtl/seg_guard_pkg.sv
package seg_guard_pkg;

  typedef enum logic [1:0] {
    RIGHTS_RW  = 2'b00,
    RIGHTS_RO  = 2'b01,
    RIGHTS_XO  = 2'b10,
    RIGHTS_SYS = 2'b11
  } rights_e;

  typedef enum logic [1:0] {
    KIND_FETCH = 2'b00,
    KIND_LOAD  = 2'b01,
    KIND_STORE = 2'b10,
    KIND_BAD   = 2'b11
  } kind_e;

  // Returns 1 when the rights class forbids the reference.
  function automatic logic rights_deny(rights_e r, kind_e k, logic sup);
    logic deny;
    if (k == KIND_BAD) begin
      deny = 1'b1;
    end else begin
      unique case (r)
        RIGHTS_RW: deny = 1'b0;
        RIGHTS_RO: deny = (k == KIND_STORE);
        RIGHTS_XO: deny = (k != KIND_FETCH);
        default:   deny = !sup;
      endcase
    end
    return deny;
  endfunction

endpackage

// File: rtl/seg_len_bound.sv
module seg_len_bound #(
  parameter int PAGE_W = 8,
  parameter int LEN_W  = 9
) (
  input  logic [PAGE_W-1:0] page,
  input  logic [LEN_W-1:0]  len,
  output logic              beyond
);
  localparam int CMP_W = (PAGE_W > LEN_W) ? PAGE_W : LEN_W;

  logic [CMP_W-1:0] page_x;
  logic [CMP_W-1:0] len_x;

  assign page_x = CMP_W'(page);
  assign len_x  = CMP_W'(len);
  assign beyond = (page_x >= len_x);
endmodule

// File: rtl/seg_rights_eval.sv
module seg_rights_eval
  import seg_guard_pkg::*;
(
  input  logic [1:0] rights,
  input  logic [1:0] kind,
  input  logic       sup,
  output logic       deny
);
  assign deny = rights_deny(rights_e'(rights), kind_e'(kind), sup);
endmodule

// File: rtl/seg_verdict_stage.sv
module seg_verdict_stage #(
  parameter bit REGISTERED = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic size_bad,
  input  logic rights_bad,
  output logic grant,
  output logic size_viol,
  output logic access_viol
);
  logic grant_d;
  assign grant_d = !size_bad && !rights_bad;

  generate
    if (REGISTERED) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          grant       <= 1'b0;
          size_viol   <= 1'b0;
          access_viol <= 1'b0;
        end else begin
          grant       <= grant_d;
          size_viol   <= size_bad;
          access_viol <= rights_bad;
        end
      end
    end else begin : g_comb
      assign grant       = grant_d;
      assign size_viol   = size_bad;
      assign access_viol = rights_bad;
    end
  endgenerate
endmodule

// File: rtl/seg_guard.sv
module seg_guard #(
  parameter int PAGE_W     = 8,
  parameter int LEN_W      = PAGE_W + 1,
  parameter bit REGISTERED = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LEN_W-1:0]  seg_len,
  input  logic [1:0]        seg_rights,
  input  logic [PAGE_W-1:0] acc_page,
  input  logic [1:0]        acc_kind,
  input  logic              acc_super,
  output logic              grant,
  output logic              size_viol,
  output logic              access_viol
);
  // Named internal events, visible to the bound checker.
  logic bound_hit;
  logic rights_hit;

  seg_len_bound #(.PAGE_W(PAGE_W), .LEN_W(LEN_W)) u_bound (
    .page   (acc_page),
    .len    (seg_len),
    .beyond (bound_hit)
  );

  seg_rights_eval u_rights (
    .rights (seg_rights),
    .kind   (acc_kind),
    .sup    (acc_super),
    .deny   (rights_hit)
  );

  seg_verdict_stage #(.REGISTERED(REGISTERED)) u_stage (
    .clk         (clk),
    .rst_n       (rst_n),
    .size_bad    (bound_hit),
    .rights_bad  (rights_hit),
    .grant       (grant),
    .size_viol   (size_viol),
    .access_viol (access_viol)
  );
endmodule

// File: rtl/seg_guard_chk.sv
module seg_guard_chk #(
  parameter int PAGE_W     = 8,
  parameter int LEN_W      = 9,
  parameter bit REGISTERED = 1'b1
) (
  input logic              clk,
  input logic              rst_n,
  input logic [LEN_W-1:0]  seg_len,
  input logic [1:0]        seg_rights,
  input logic [PAGE_W-1:0] acc_page,
  input logic [1:0]        acc_kind,
  input logic              acc_super,
  input logic              grant,
  input logic              size_viol,
  input logic              access_viol,
  input logic              bound_hit,
  input logic              rights_hit
);
  logic armed;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  // R8
  grant_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    grant |-> (!size_viol && !access_viol));

  generate
    if (REGISTERED) begin : g_reg_chk
      // R9
      reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (!grant && !size_viol && !access_viol));
      // R1
      size_flag_chk: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        size_viol == $past(bound_hit));
      // R7
      bad_kind_chk: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        $past(acc_kind == 2'b11) |-> access_viol);
      // R4
      exec_only_chk: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        $past(seg_rights == 2'b10 && acc_kind != 2'b00) |-> access_viol);
      // R5
      sys_user_chk: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        $past(seg_rights == 2'b11 && !acc_super) |-> !grant);
      // R2
      rw_open_chk: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        $past(seg_rights == 2'b00 && acc_kind != 2'b11) |-> !access_viol);
    end else begin : g_comb_chk
      // R1
      size_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        size_viol == bound_hit);
      // R7
      bad_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_kind == 2'b11) |-> access_viol);
      // R4
      exec_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seg_rights == 2'b10 && acc_kind != 2'b00) |-> access_viol);
      // R5
      sys_user_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seg_rights == 2'b11 && !acc_super) |-> !grant);
      // R2
      rw_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seg_rights == 2'b00 && acc_kind != 2'b11) |-> !access_viol);
    end
  endgenerate

  // R3
  ro_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seg_rights == 2'b01 && acc_kind == 2'b10) |-> rights_hit);
endmodule

bind seg_guard seg_guard_chk #(
  .PAGE_W(PAGE_W), .LEN_W(LEN_W), .REGISTERED(REGISTERED)
) u_guard_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .seg_len     (seg_len),
  .seg_rights  (seg_rights),
  .acc_page    (acc_page),
  .acc_kind    (acc_kind),
  .acc_super   (acc_super),
  .grant       (grant),
  .size_viol   (size_viol),
  .access_viol (access_viol),
  .bound_hit   (bound_hit),
  .rights_hit  (rights_hit)
);

// File: tb/seg_guard_bench.sv
module seg_guard_bench;
  localparam int PAGE_W = 8;
  localparam int LEN_W  = 9;
  localparam int NVEC   = 23;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [LEN_W-1:0]  seg_len = '0;
  logic [1:0]        seg_rights = '0;
  logic [PAGE_W-1:0] acc_page = '0;
  logic [1:0]        acc_kind = '0;
  logic              acc_super = 1'b0;
  logic              r_grant, r_size, r_acc;
  logic              c_grant, c_size, c_acc;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  seg_guard #(.PAGE_W(PAGE_W), .LEN_W(LEN_W), .REGISTERED(1'b1)) u_seg_guard (
    .clk(clk), .rst_n(rst_n), .seg_len(seg_len), .seg_rights(seg_rights),
    .acc_page(acc_page), .acc_kind(acc_kind), .acc_super(acc_super),
    .grant(r_grant), .size_viol(r_size), .access_viol(r_acc)
  );

  seg_guard #(.PAGE_W(PAGE_W), .LEN_W(LEN_W), .REGISTERED(1'b0)) u_seg_guard_comb (
    .clk(clk), .rst_n(rst_n), .seg_len(seg_len), .seg_rights(seg_rights),
    .acc_page(acc_page), .acc_kind(acc_kind), .acc_super(acc_super),
    .grant(c_grant), .size_viol(c_size), .access_viol(c_acc)
  );

  // {tag, len, page, rights, kind, super, expected {grant,size,access}}
  // kinds: 0 fetch, 1 load, 2 store, 3 invalid
  localparam logic [28:0] VEC [NVEC] = '{
    {4'd2, 9'd5,   8'd2,   2'd0, 2'd0, 1'b0, 3'b100},
    {4'd2, 9'd5,   8'd2,   2'd0, 2'd1, 1'b0, 3'b100},
    {4'd2, 9'd5,   8'd2,   2'd0, 2'd2, 1'b0, 3'b100},
    {4'd3, 9'd5,   8'd4,   2'd1, 2'd0, 1'b0, 3'b100},
    {4'd3, 9'd5,   8'd4,   2'd1, 2'd1, 1'b0, 3'b100},
    {4'd3, 9'd5,   8'd4,   2'd1, 2'd2, 1'b0, 3'b001},
    {4'd4, 9'd5,   8'd0,   2'd2, 2'd0, 1'b0, 3'b100},
    {4'd4, 9'd5,   8'd0,   2'd2, 2'd1, 1'b0, 3'b001},
    {4'd4, 9'd5,   8'd0,   2'd2, 2'd2, 1'b0, 3'b001},
    {4'd5, 9'd5,   8'd1,   2'd3, 2'd0, 1'b0, 3'b001},
    {4'd5, 9'd5,   8'd1,   2'd3, 2'd1, 1'b0, 3'b001},
    {4'd5, 9'd5,   8'd1,   2'd3, 2'd2, 1'b0, 3'b001},
    {4'd5, 9'd5,   8'd1,   2'd3, 2'd0, 1'b1, 3'b100},
    {4'd5, 9'd5,   8'd1,   2'd3, 2'd2, 1'b1, 3'b100},
    {4'd6, 9'd5,   8'd1,   2'd1, 2'd2, 1'b1, 3'b001},
    {4'd6, 9'd5,   8'd1,   2'd2, 2'd1, 1'b1, 3'b001},
    {4'd1, 9'd5,   8'd5,   2'd0, 2'd1, 1'b0, 3'b010},
    {4'd1, 9'd0,   8'd0,   2'd0, 2'd0, 1'b0, 3'b010},
    {4'd1, 9'd256, 8'd255, 2'd0, 2'd2, 1'b0, 3'b100},
    {4'd8, 9'd3,   8'd200, 2'd2, 2'd2, 1'b0, 3'b011},
    {4'd7, 9'd5,   8'd1,   2'd0, 2'd3, 1'b0, 3'b001},
    {4'd7, 9'd5,   8'd1,   2'd3, 2'd3, 1'b1, 3'b001},
    {4'd6, 9'd1,   8'd0,   2'd0, 2'd0, 1'b1, 3'b100}
  };

  function automatic string tag_name(logic [3:0] t);
    case (t)
      4'd1: return "R1";
      4'd2: return "R2";
      4'd3: return "R3";
      4'd4: return "R4";
      4'd5: return "R5";
      4'd6: return "R6";
      4'd7: return "R7";
      4'd8: return "R8";
      4'd9: return "R9";
      default: return "R10";
    endcase
  endfunction

  task automatic check3(string req, string what, logic [2:0] got, logic [2:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: got grant/size/access=%b expected %b", req, what, got, exp);
    end
  endtask

  task automatic drive(logic [LEN_W-1:0] l, logic [PAGE_W-1:0] p, logic [1:0] r,
                       logic [1:0] k, logic s);
    seg_len = l; seg_rights = r; acc_page = p; acc_kind = k; acc_super = s;
  endtask

  initial begin
    // R9: reset holds registered outputs low while inputs would grant
    drive(9'd5, 8'd1, 2'd0, 2'd0, 1'b0);
    repeat (2) @(posedge clk);
    #1;
    check3("R9", "during reset", {r_grant, r_size, r_acc}, 3'b000);
    // R10: the direct path ignores reset
    check3("R10", "comb during reset", {c_grant, c_size, c_acc}, 3'b100);
    @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk);
      drive(VEC[i][24:16], VEC[i][15:8], VEC[i][7:6], VEC[i][5:4], VEC[i][3]);
      #1;
      check3(tag_name(VEC[i][28:25]), $sformatf("comb vec %0d", i),
             {c_grant, c_size, c_acc}, VEC[i][2:0]);
      @(posedge clk);
      #1;
      check3(tag_name(VEC[i][28:25]), $sformatf("reg vec %0d", i),
             {r_grant, r_size, r_acc}, VEC[i][2:0]);
    end

    // R9: one-cycle latency, old result held until the next edge
    @(negedge clk);
    drive(9'd5, 8'd1, 2'd0, 2'd0, 1'b0);
    @(posedge clk); #1;
    check3("R9", "latency grant", {r_grant, r_size, r_acc}, 3'b100);
    @(negedge clk);
    drive(9'd5, 8'd1, 2'd2, 2'd2, 1'b0);
    #1;
    check3("R9", "held before edge", {r_grant, r_size, r_acc}, 3'b100);
    check3("R10", "comb same cycle", {c_grant, c_size, c_acc}, 3'b001);
    @(posedge clk); #1;
    check3("R9", "after edge", {r_grant, r_size, r_acc}, 3'b001);

    // R9: asynchronous clear mid-run
    @(negedge clk);
    drive(9'd5, 8'd1, 2'd0, 2'd0, 1'b0);
    @(posedge clk); #1;
    check3("R9", "pre-reset grant", {r_grant, r_size, r_acc}, 3'b100);
    #2;
    rst_n = 1'b0;
    #1;
    check3("R9", "async clear", {r_grant, r_size, r_acc}, 3'b000);
    @(negedge clk);
    rst_n = 1'b1;

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule